// File: doc/BRIEF.md
# Infrared-Modulated Serial Transmitter

This block sends bytes as asynchronous serial frames. It can also chop the serial line with a pulse-width carrier so that the pin can drive an infrared emitter directly. It has three parts. A serialiser turns each accepted byte into a frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts a programmable number of clock cycles. A free-running carrier counter produces a rectangular wave whose period and high time are programmable. An output stage either forwards the serial line to the pin unchanged or ANDs it with the carrier. With the AND, every high bit on the line becomes a burst of carrier pulses and every low bit stays dark.

Bytes enter through a valid/ready handshake. A byte is taken only while the serialiser is idle. The carrier counter has its own enable. While modulation is switched on, the carrier belongs to the modulator alone, and its own external output is held low. The period and compare settings pass through shadow registers. A change made while the counter runs is held back until the counter wraps, so no carrier pulse is ever cut short or stretched.

Top module: `irtx_top`

## Requirements
- R1: During and directly after reset, `tx_pin` is 1, `carrier_pin` is 0 and `tx_ready` is 1.
- R2: A frame on the line is one start bit of value 0, then `tx_data[0]` through `tx_data[7]` in that order, then one stop bit of value 1. Between frames the line stays at 1.
- R3: Every bit of a frame lasts exactly `baud_div` clock cycles, using the value sampled on the accepting edge. A `baud_div` of 0 behaves as 1.
- R4: `tx_ready` is 1 exactly when no frame is in progress. A byte is taken on a rising edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` drops on that edge and rises again when the stop bit has lasted its full time. `tx_valid` and `tx_data` have no effect while `tx_ready` is 0.
- R5: While `pwm_en` is 1, the carrier counter steps 0, 1, … up to the active modulo value and then returns to 0, giving a period of modulo+1 cycles. The carrier is 1 while the count is below the active compare value and 0 otherwise.
- R6: An active compare value of 0 gives a carrier that is always 0. A compare value greater than the modulo value gives a carrier that is always 1.
- R7: While `pwm_en` is 1, new `pwm_mod`/`pwm_cmp` values become active only on the edge where the counter wraps to 0. While `pwm_en` is 0, the counter is held at 0, the carrier is 0, and the inputs are copied into the active registers on every edge.
- R8: With `mod_en` at 1, `tx_pin` is the AND of the serial line and the carrier.
- R9: With `mod_en` at 0, `tx_pin` follows the serial line and the carrier has no effect on it.
- R10: With `mod_en` at 0, `carrier_pin` shows the carrier. With `mod_en` at 1, `carrier_pin` is held at 0.
- R11: Both pins are registered, so they lag the internal line and carrier by one clock. The start bit appears on `tx_pin` after the first rising edge that follows the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte to send |
| tx_ready | output | 1 | Serialiser idle, a byte can be taken |
| baud_div | input | DIV_W | Clock cycles per bit (0 behaves as 1) |
| pwm_mod | input | PWM_W | Carrier counter top value (period is value+1) |
| pwm_cmp | input | PWM_W | Carrier compare value (sets the high time) |
| pwm_en | input | 1 | Carrier counter runs |
| mod_en | input | 1 | AND the serial line with the carrier |
| tx_pin | output | 1 | Serial output pin |
| carrier_pin | output | 1 | Carrier's own output, held low while modulating |

## Verification
The hardest case to reach is a settings change that lands in the middle of a carrier period, together with a frame whose bit edges fall at some random phase of that carrier. The bench keeps the carrier running and rewrites the modulo and compare inputs every few cycles on a schedule that is prime to the period, so the writes land at every count. The bench tracks the counter on its own and expects the old values until the next wrap. Separately, it runs a sweep over all small modulo/compare pairs while a frame is modulated, including the all-dark and all-lit compare settings. A burst of back-to-back requests with `tx_valid` held high and the data changing every cycle shows that only the byte present on the accepting edge is sent.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

   typedef enum logic [1:0] {
      SER_IDLE  = 2'd0,
      SER_START = 2'd1,
      SER_DATA  = 2'd2,
      SER_STOP  = 2'd3
   } ser_state_e;

   // bit cycle reload value: a divisor of zero is treated as one
   function automatic logic [31:0] reload_of(input logic [31:0] div);
      return (div == 32'd0) ? 32'd0 : div - 32'd1;
   endfunction

endpackage

// File: rtl/irtx_serializer.sv
module irtx_serializer
   import irtx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DIV_W-1:0]  bit_div,
   output logic              line_o
);

   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   ser_state_e         state_q;
   logic [DIV_W-1:0]   cyc_q;
   logic [DIV_W-1:0]   reload_q;
   logic [IDX_W-1:0]   idx_q;
   logic [DATA_W-1:0]  shift_q;
   logic [DIV_W-1:0]   reload_in;
   logic               bit_done;

   assign reload_in = DIV_W'(reload_of(32'(bit_div)));
   assign bit_done  = (cyc_q == '0);
   assign in_ready  = (state_q == SER_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SER_IDLE;
         cyc_q    <= '0;
         reload_q <= '0;
         idx_q    <= '0;
         shift_q  <= '0;
      end else begin
         unique case (state_q)
            SER_IDLE: begin
               if (in_valid) begin
                  shift_q  <= in_data;
                  reload_q <= reload_in;
                  cyc_q    <= reload_in;
                  state_q  <= SER_START;
               end
            end
            SER_START: begin
               if (bit_done) begin
                  cyc_q   <= reload_q;
                  idx_q   <= '0;
                  state_q <= SER_DATA;
               end else begin
                  cyc_q <= cyc_q - 1'b1;
               end
            end
            SER_DATA: begin
               if (bit_done) begin
                  cyc_q   <= reload_q;
                  shift_q <= shift_q >> 1;
                  if (idx_q == LAST_IDX) begin
                     state_q <= SER_STOP;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end else begin
                  cyc_q <= cyc_q - 1'b1;
               end
            end
            SER_STOP: begin
               if (bit_done) begin
                  state_q <= SER_IDLE;
               end else begin
                  cyc_q <= cyc_q - 1'b1;
               end
            end
            default: state_q <= SER_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (state_q)
         SER_START: line_o = 1'b0;
         SER_DATA:  line_o = shift_q[0];
         default:   line_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
   parameter int PWM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PWM_W-1:0] mod_in,
   input  logic [PWM_W-1:0] cmp_in,
   output logic [PWM_W-1:0] cnt_o,
   output logic [PWM_W-1:0] mod_act_o,
   output logic [PWM_W-1:0] cmp_act_o,
   output logic             wave_o
);

   logic [PWM_W-1:0] cnt_q;
   logic [PWM_W-1:0] mod_q;
   logic [PWM_W-1:0] cmp_q;
   logic             wrap;

   assign wrap = (cnt_q == mod_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mod_q <= '0;
         cmp_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
         mod_q <= mod_in;
         cmp_q <= cmp_in;
      end else if (wrap) begin
         cnt_q <= '0;
         mod_q <= mod_in;
         cmp_q <= cmp_in;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign wave_o    = run && (cnt_q < cmp_q);
   assign cnt_o     = cnt_q;
   assign mod_act_o = mod_q;
   assign cmp_act_o = cmp_q;

endmodule

// File: rtl/irtx_outstage.sv
module irtx_outstage #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic wave_i,
   input  logic gate_en,
   output logic pin_o,
   output logic wave_pin_o
);

   logic pin_d;
   logic wave_d;

   assign pin_d  = gate_en ? (line_i & wave_i) : line_i;
   assign wave_d = gate_en ? 1'b0 : wave_i;

   if (OUT_REG) begin : g_reg
      logic pin_q;
      logic wave_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pin_q  <= 1'b1;
            wave_q <= 1'b0;
         end else begin
            pin_q  <= pin_d;
            wave_q <= wave_d;
         end
      end
      assign pin_o      = pin_q;
      assign wave_pin_o = wave_q;
   end else begin : g_comb
      assign pin_o      = pin_d;
      assign wave_pin_o = wave_d;
   end

endmodule

// File: rtl/irtx_top.sv
module irtx_top #(
   parameter int DATA_W  = 8,
   parameter int DIV_W   = 16,
   parameter int PWM_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic [PWM_W-1:0]  pwm_mod,
   input  logic [PWM_W-1:0]  pwm_cmp,
   input  logic              pwm_en,
   input  logic              mod_en,
   output logic              tx_pin,
   output logic              carrier_pin
);

   if (DATA_W != 8) begin : g_bad_data
      $error("irtx_top: frame format fixes DATA_W at 8");
   end
   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
      $error("irtx_top: DIV_W must be 1..32");
   end
   if (PWM_W < 1 || PWM_W > 32) begin : g_bad_pwm
      $error("irtx_top: PWM_W must be 1..32");
   end

   logic             ser_line;
   logic             carrier;
   logic [PWM_W-1:0] pwm_cnt;
   logic [PWM_W-1:0] pwm_mod_act;
   logic [PWM_W-1:0] pwm_cmp_act;

   irtx_serializer #(
      .DATA_W (DATA_W),
      .DIV_W  (DIV_W)
   ) ser_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (tx_data),
      .in_valid (tx_valid),
      .in_ready (tx_ready),
      .bit_div  (baud_div),
      .line_o   (ser_line)
   );

   irtx_carrier #(
      .PWM_W (PWM_W)
   ) car_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (pwm_en),
      .mod_in    (pwm_mod),
      .cmp_in    (pwm_cmp),
      .cnt_o     (pwm_cnt),
      .mod_act_o (pwm_mod_act),
      .cmp_act_o (pwm_cmp_act),
      .wave_o    (carrier)
   );

   irtx_outstage #(
      .OUT_REG (OUT_REG)
   ) out_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (ser_line),
      .wave_i     (carrier),
      .gate_en    (mod_en),
      .pin_o      (tx_pin),
      .wave_pin_o (carrier_pin)
   );

endmodule

// File: rtl/irtx_chk.sv
module irtx_chk #(
   parameter int PWM_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic             pwm_en,
   input logic             mod_en,
   input logic             tx_pin,
   input logic             carrier_pin,
   input logic             carrier,
   input logic [PWM_W-1:0] cnt,
   input logic [PWM_W-1:0] mod_act,
   input logic [PWM_W-1:0] cmp_act
);

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready); // R4

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_en |-> (cnt <= mod_act)); // R5

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && cnt == mod_act) |=> (cnt == '0)); // R5

   AST_ZERO_CMP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act == '0) |-> !carrier); // R6

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && cnt != mod_act) |=> ($stable(mod_act) && $stable(cmp_act))); // R7

   if (OUT_REG) begin : g_reg_props
      AST_START_ON_PIN: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_valid && tx_ready) |=> ##1 !tx_pin); // R11

      AST_GATED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_en && !carrier) |=> !tx_pin); // R8

      AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         (!mod_en && tx_ready) |=> tx_pin); // R9

      AST_CAR_DEDICATED: assert property (@(posedge clk) disable iff (!rst_n)
         mod_en |=> !carrier_pin); // R10
   end else begin : g_comb_props
      AST_GATED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_en && !carrier) |-> !tx_pin); // R8

      AST_CAR_DEDICATED: assert property (@(posedge clk) disable iff (!rst_n)
         mod_en |-> !carrier_pin); // R10
   end

endmodule

bind irtx_top irtx_chk #(
   .PWM_W   (PWM_W),
   .OUT_REG (OUT_REG)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .pwm_en      (pwm_en),
   .mod_en      (mod_en),
   .tx_pin      (tx_pin),
   .carrier_pin (carrier_pin),
   .carrier     (carrier),
   .cnt         (pwm_cnt),
   .mod_act     (pwm_mod_act),
   .cmp_act     (pwm_cmp_act)
);

// File: tb/irtx_top_tb_top.sv
`timescale 1ns/1ps
module irtx_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  tx_data = '0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [15:0] baud_div = 16'd1;
   logic [7:0]  pwm_mod = '0;
   logic [7:0]  pwm_cmp = '0;
   logic        pwm_en = 1'b0;
   logic        mod_en = 1'b0;
   logic        tx_pin;
   logic        carrier_pin;

   always #2.5 clk = ~clk;

   irtx_top dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_data     (tx_data),
      .tx_valid    (tx_valid),
      .tx_ready    (tx_ready),
      .baud_div    (baud_div),
      .pwm_mod     (pwm_mod),
      .pwm_cmp     (pwm_cmp),
      .pwm_en      (pwm_en),
      .mod_en      (mod_en),
      .tx_pin      (tx_pin),
      .carrier_pin (carrier_pin)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;
   string cur_req = "R1";

   task automatic chk(input bit ok, input string what, input logic act, input logic exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%b exp=%b at %0t", what, act, exp, $time);
      end
   endtask

   // reference model state
   bit       m_act;
   int       m_j, m_d;
   bit [7:0] m_byte;
   int       m_pc, m_meff, m_ceff, m_pc_p, m_ceff_p;
   bit       m_ser_p;

   function automatic bit frame_bit(input int idx, input bit [7:0] b);
      if (idx == 0) return 1'b0;
      if (idx >= 9) return 1'b1;
      return b[idx-1];
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_j = 0; m_d = 1; m_byte = '0;
         m_pc = 0; m_meff = 0; m_ceff = 0; m_pc_p = 0; m_ceff_p = 0;
         m_ser_p = 1'b1;
      end else if (!done) begin
         bit exp_car, exp_pin, exp_cp;
         exp_car = pwm_en && (m_pc_p < m_ceff_p);
         exp_pin = mod_en ? (m_ser_p & exp_car) : m_ser_p;
         exp_cp  = mod_en ? 1'b0 : exp_car;
         chk(tx_pin === exp_pin,
             $sformatf("%s %s tx_pin", mod_en ? "R8" : "R9", cur_req), tx_pin, exp_pin);
         chk(carrier_pin === exp_cp,
             $sformatf("%s %s carrier_pin", mod_en ? "R10" : "R5", cur_req), carrier_pin, exp_cp);
         // serialiser model for the edge just passed
         if (m_act) begin
            m_j++;
            if (m_j == 10 * m_d) m_act = 0;
         end else if (tx_valid) begin
            m_act = 1; m_j = 0; m_byte = tx_data;
            m_d = (baud_div == 0) ? 1 : int'(baud_div);
         end
         // carrier model
         if (pwm_en) begin
            if (m_pc == m_meff) begin
               m_pc = 0; m_meff = pwm_mod; m_ceff = pwm_cmp;
            end else begin
               m_pc++;
            end
         end else begin
            m_pc = 0; m_meff = pwm_mod; m_ceff = pwm_cmp;
         end
         chk(tx_ready === !m_act, $sformatf("R4 %s tx_ready", cur_req), tx_ready, !m_act);
         m_pc_p   = m_pc;
         m_ceff_p = m_ceff;
         m_ser_p  = m_act ? frame_bit(m_j / m_d, m_byte) : 1'b1;
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic send(input logic [7:0] b);
      step();
      while (tx_ready !== 1'b1) step();
      tx_data = b; tx_valid = 1'b1;
      step();
      tx_valid = 1'b0;
      step();
      while (tx_ready !== 1'b1) step();
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(tx_pin === 1'b1, "R1 tx_pin in reset", tx_pin, 1'b1);
      chk(carrier_pin === 1'b0, "R1 carrier_pin in reset", carrier_pin, 1'b0);
      chk(tx_ready === 1'b1, "R1 tx_ready in reset", tx_ready, 1'b1);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(tx_pin === 1'b1, "R1 tx_pin after reset", tx_pin, 1'b1);
      #1;

      // R2 R3 R11: plain frames across divisors and data patterns
      cur_req = "R2 R3 R11";
      foreach (baud_div[i]) begin end
      for (int di = 0; di < 4; di++) begin
         baud_div = (di == 3) ? 16'd5 : 16'(di + 1);
         for (int bi = 0; bi < 6; bi++) begin
            logic [7:0] pat [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
            send(pat[bi]);
         end
      end

      // R3: zero divisor behaves as one
      cur_req = "R3";
      baud_div = 16'd0;
      send(8'h3C);

      // R4: valid held high, data changes every cycle
      cur_req = "R4";
      baud_div = 16'd2;
      tx_valid = 1'b1;
      for (int k = 0; k < 70; k++) begin
         tx_data = 8'(k * 37 + 11);
         step();
      end
      tx_valid = 1'b0;
      step();
      while (tx_ready !== 1'b1) step();

      // R5 R6 R8 R10: exhaustive small modulo/compare sweep with modulation
      cur_req = "R5 R6 R8 R10";
      baud_div = 16'd3;
      for (int m = 0; m < 6; m++) begin
         for (int c = 0; c < 8; c++) begin
            pwm_en = 1'b0; pwm_mod = 8'(m); pwm_cmp = 8'(c);
            step();
            pwm_en = 1'b1;
            mod_en = 1'b1;
            send(8'hC6);
            mod_en = 1'b0;
            repeat (8) step();
         end
      end

      // R7: settings rewritten mid-period, and carrier stopped mid-period
      cur_req = "R7";
      pwm_en = 1'b0; pwm_mod = 8'd7; pwm_cmp = 8'd3;
      step();
      pwm_en = 1'b1;
      for (int k = 0; k < 60; k++) begin
         if (k % 3 == 0) begin
            pwm_cmp = 8'(k % 9);
            pwm_mod = 8'(4 + (k % 5));
         end
         if (k == 40) mod_en = 1'b1;
         if (k == 45) begin tx_data = 8'h96; tx_valid = 1'b1; end
         if (k == 46) tx_valid = 1'b0;
         if (k == 55) pwm_en = 1'b0;
         if (k == 57) pwm_en = 1'b1;
         step();
      end
      while (tx_ready !== 1'b1) step();
      mod_en = 1'b0;
      repeat (20) step();

      finish_run();
   end

endmodule